// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller that runs a 10-bit successive-approximation converter. Software starts a conversion by setting a start/busy bit. The sequencer first holds the sample switch closed for a programmable number of conversion clock periods. It then opens the switch to isolate the held sample, spends one period on setup, and resolves the result from the most significant bit down. It forms each trial code for the DAC and keeps or drops the trial bit according to an external comparator.

When the last bit is decided, the result register is loaded, the busy bit drops, a sticky interrupt flag rises and the sample switch closes again, all on the same clock edge. Software may clear the busy bit at any time during a conversion to abort it. An abort leaves the result register holding whatever it held before. Every completion or abort is followed by a discharge wait of two conversion clock periods before the sequencer accepts a new start. A start requested during that wait is kept and acted on once the wait ends.

All sequencing moves only on a one-cycle conversion clock enable, which a clock divider elsewhere produces. The analog parts and the channel selection are outside this block.

Top module: `sar_seq`

## Requirements
- R1: After reset the result is 0, the interrupt flag and busy bit are 0, the sample switch control is 1 (closed) and the DAC code is 0.
- R2: Bits are resolved from bit 9 to bit 0, one per enable period. The trial code on `dac_code` is the bits kept so far plus the bit under test. The bit is kept when `cmp_hi` is 1 (input at or above the trial code), so the first trial code is 0x200 and the final result equals the input level.
- R3: The acquisition code on `acq_code` selects 0, 2, 4, 6, 8, 12, 16 or 20 enable periods for codes 0 to 7. The start is taken on the first enable after the start bit is registered. The result appears on the enable that is acquisition + 12 enables after the start request.
- R4: `sample_on` is 1 while idle, acquiring and discharging, and is 0 during the setup period and the ten bit decisions.
- R5: On completion, the result load, the clearing of the busy bit and the setting of the interrupt flag happen on the same clock edge.
- R6: Clearing the busy bit during acquisition, setup or bit decisions aborts the conversion on the next enable. The result keeps its previous value and the flag is not set.
- R7: After completion or abort the sequencer waits 2 enable periods before it can begin again. A start requested during this wait stays pending and begins on the enable after the wait.
- R8: The interrupt flag stays set until `irq_clr` is pulsed. A set on the same edge as a clear wins.
- R9: A pulse on `res_wr` writes `res_wdata` into the result register on the next clock edge. A conversion load on the same edge takes priority.
- R10: State, counters and the DAC code change only on clock edges where `tick_en` is 1. All delays are counted in enable periods, not system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle conversion clock enable |
| go_set | input | 1 | Software request to set the start/busy bit |
| go_clr | input | 1 | Software request to clear the start/busy bit (abort) |
| acq_code | input | 3 | Acquisition time select |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the DAC trial code |
| res_wr | input | 1 | Software write strobe for the result register |
| res_wdata | input | 10 | Data for a software result write |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| go_busy | output | 1 | Start/busy bit as read by software |
| result | output | 10 | Result register |
| irq_flag | output | 1 | Sticky conversion-complete flag |
| dac_code | output | 10 | Trial code for the DAC, 0 outside bit decisions |
| sample_on | output | 1 | Sample switch control, 1 = connected to input |

## Verification
The bench builds the block with its default parameters: 10 result bits, a 5-bit period counter and a 2-period discharge. The enable arrives every third system clock. The 5-bit counter reaches the longest acquisition setting of 20 periods, so every acquisition code is timed against its own latency. The sparse enable shows that every delay is counted in enable periods rather than clocks. The 2-period discharge makes back-to-back starts, and a start issued right after an abort, land inside the wait, which exercises the held-request path.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_SETUP,
        ST_CONV,
        ST_DISCH
    } seq_state_e;

    // Acquisition length in conversion enable periods for each select code
    function automatic logic [7:0] acq_periods(input logic [2:0] code);
        logic [7:0] n;
        case (code)
            3'd0:    n = 8'd0;
            3'd1:    n = 8'd2;
            3'd2:    n = 8'd4;
            3'd3:    n = 8'd6;
            3'd4:    n = 8'd8;
            3'd5:    n = 8'd12;
            3'd6:    n = 8'd16;
            default: n = 8'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sar_tick_counter.sv
module sar_tick_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (dec)  count <= count - 1'b1;
    end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] resolved,
    output logic             last_bit
);
    logic [RES_W-1:0] kept_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] bit_mask;

    assign bit_mask = RES_W'(1) << idx_q;
    assign trial    = kept_q | bit_mask;
    assign resolved = cmp_hi ? trial : kept_q;
    assign last_bit = (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            kept_q <= '0;
            idx_q  <= IDX_W'(RES_W - 1);
        end else if (start) begin
            kept_q <= '0;
            idx_q  <= IDX_W'(RES_W - 1);
        end else if (step) begin
            kept_q <= resolved;
            idx_q  <= idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_ld,
    input  logic [RES_W-1:0] conv_val,
    input  logic             sw_wr,
    input  logic [RES_W-1:0] sw_val,
    input  logic             flag_clr,
    output logic [RES_W-1:0] value,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flag  <= 1'b0;
        end else begin
            if (conv_ld)    value <= conv_val;
            else if (sw_wr) value <= sw_val;
            if (conv_ld)       flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int CNT_W       = 5,
    parameter int DISCH_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             go_set,
    input  logic             go_clr,
    input  logic [2:0]       acq_code,
    input  logic             cmp_hi,
    input  logic             res_wr,
    input  logic [RES_W-1:0] res_wdata,
    input  logic             irq_clr,
    output logic             go_busy,
    output logic [RES_W-1:0] result,
    output logic             irq_flag,
    output logic [RES_W-1:0] dac_code,
    output logic             sample_on
);
    localparam logic [CNT_W-1:0] DISCH_LEN = CNT_W'(DISCH_TICKS);

    seq_state_e       state_q, state_d;
    logic             go_q, go_d;
    logic             cnt_load, cnt_dec;
    logic [CNT_W-1:0] cnt_val, cnt_q;
    logic             sar_start, sar_step, sar_last;
    logic [RES_W-1:0] sar_trial, sar_resolved;
    logic             res_ld;
    logic [CNT_W-1:0] acq_len;

    assign acq_len = CNT_W'(acq_periods(acq_code));

    always_comb begin
        state_d   = state_q;
        go_d      = go_q;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        sar_start = 1'b0;
        sar_step  = 1'b0;
        res_ld    = 1'b0;

        if (go_clr)
            go_d = 1'b0;
        else if (go_set && (state_q == ST_IDLE || state_q == ST_DISCH))
            go_d = 1'b1;

        if (tick_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_q) begin
                        if (acq_len == '0) begin
                            state_d = ST_SETUP;
                        end else begin
                            state_d  = ST_ACQ;
                            cnt_load = 1'b1;
                            cnt_val  = acq_len;
                        end
                    end
                end
                ST_ACQ, ST_SETUP, ST_CONV: begin
                    if (!go_q) begin
                        state_d  = ST_DISCH;
                        cnt_load = 1'b1;
                        cnt_val  = DISCH_LEN;
                    end else if (state_q == ST_ACQ) begin
                        if (cnt_q == CNT_W'(1)) state_d = ST_SETUP;
                        else                    cnt_dec = 1'b1;
                    end else if (state_q == ST_SETUP) begin
                        state_d   = ST_CONV;
                        sar_start = 1'b1;
                    end else begin
                        sar_step = 1'b1;
                        if (sar_last) begin
                            res_ld   = 1'b1;
                            go_d     = 1'b0;
                            state_d  = ST_DISCH;
                            cnt_load = 1'b1;
                            cnt_val  = DISCH_LEN;
                        end
                    end
                end
                ST_DISCH: begin
                    if (cnt_q == CNT_W'(1)) state_d = ST_IDLE;
                    else                    cnt_dec = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
        end
    end

    sar_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .count    (cnt_q)
    );

    sar_approx_reg #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .start    (sar_start),
        .step     (sar_step),
        .cmp_hi   (cmp_hi),
        .trial    (sar_trial),
        .resolved (sar_resolved),
        .last_bit (sar_last)
    );

    sar_result_reg #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .conv_ld  (res_ld),
        .conv_val (sar_resolved),
        .sw_wr    (res_wr),
        .sw_val   (res_wdata),
        .flag_clr (irq_clr),
        .value    (result),
        .flag     (irq_flag)
    );

    assign go_busy   = go_q;
    assign dac_code  = (state_q == ST_CONV) ? sar_trial : '0;
    assign sample_on = !(state_q == ST_SETUP || state_q == ST_CONV);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             res_wr,
    input logic             irq_clr,
    input logic             go_busy,
    input logic [RES_W-1:0] result,
    input logic             irq_flag,
    input logic [RES_W-1:0] dac_code,
    input logic             sample_on
);
    p_done_same_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> !go_busy && $fell(go_busy));

    p_switch_open_r4: assert property (@(posedge clk) disable iff (rst)
        (dac_code != '0) |-> !sample_on);

    p_dac_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_en) |-> $stable(dac_code));

    p_result_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(res_wr) && !$fell(go_busy)) |-> $stable(result));

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_clr) && !$fell(go_busy)) |-> !irq_flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .res_wr    (res_wr),
    .irq_clr   (irq_clr),
    .go_busy   (go_busy),
    .result    (result),
    .irq_flag  (irq_flag),
    .dac_code  (dac_code),
    .sample_on (sample_on)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int RES_W = 10;
    localparam int DIV   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_en = 1'b0;
    logic             go_set = 1'b0, go_clr = 1'b0;
    logic [2:0]       acq_code = '0;
    logic             cmp_hi;
    logic             res_wr = 1'b0;
    logic [RES_W-1:0] res_wdata = '0;
    logic             irq_clr = 1'b0;
    logic             go_busy, irq_flag, sample_on;
    logic [RES_W-1:0] result, dac_code;
    logic [RES_W-1:0] vin = '0;

    sar_seq u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .go_set(go_set), .go_clr(go_clr),
        .acq_code(acq_code), .cmp_hi(cmp_hi), .res_wr(res_wr), .res_wdata(res_wdata),
        .irq_clr(irq_clr), .go_busy(go_busy), .result(result), .irq_flag(irq_flag),
        .dac_code(dac_code), .sample_on(sample_on)
    );

    always #10 clk = ~clk;

    // ideal comparator: input at or above trial code
    assign cmp_hi = (dac_code <= vin);

    int unsigned pc = 0;
    int          divc = 0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always @(posedge clk) if (!rst && tick_en) pc <= pc + 1;

    always @(negedge clk) begin
        if (rst) begin
            divc    <= 0;
            tick_en <= 1'b0;
        end else begin
            divc    <= (divc == DIV-1) ? 0 : divc + 1;
            tick_en <= (divc == DIV-1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [RES_W-1:0] res;
        int unsigned      tick;
    } exp_t;
    exp_t sb[$];

    function automatic int unsigned acq_n(input logic [2:0] c);
        case (c)
            3'd0: return 0;   3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;   3'd5: return 12; 3'd6: return 16; default: return 20;
        endcase
    endfunction

    // monitor: pop expected item on each rising interrupt flag
    logic prev_flag = 1'b0;
    always @(negedge clk) begin
        prev_flag <= irq_flag;
        if (!rst && irq_flag && !prev_flag) begin
            if (sb.size() == 0) begin
                check(0, "R6 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, "R2 result", result, e.res);
                check(pc == e.tick, "R3 R10 completion tick", pc, e.tick);
                check(go_busy == 1'b0, "R5 busy cleared with flag", go_busy, 0);
                check(sample_on == 1'b1, "R4 switch closed after load", sample_on, 1);
            end
        end
    end

    int unsigned free_tick = 0;
    logic [RES_W-1:0] last_res = '0;

    function automatic int unsigned adj_pc();
        return pc + (tick_en ? 1 : 0);
    endfunction

    task automatic wait_pc(input int unsigned x);
        while (pc < x) @(negedge clk);
    endtask

    task automatic start_conv(input logic [2:0] code, input logic [RES_W-1:0] v,
                              input bit push, input bit probe, output int unsigned base);
        int unsigned s, n;
        exp_t e;
        @(negedge clk); #1;
        vin = v; acq_code = code; irq_clr = 1'b1; go_set = 1'b1;
        s = adj_pc();
        n = acq_n(code);
        base = (s > free_tick) ? s : free_tick;
        if (push) begin
            e.res = v; e.tick = base + n + 12;
            sb.push_back(e);
        end
        @(negedge clk); #1;
        go_set = 1'b0; irq_clr = 1'b0;
        if (probe) begin
            wait_pc(base + 1);
            if (n > 0) check(sample_on == 1'b1, "R4 switch closed in acquisition", sample_on, 1);
            check(go_busy == 1'b1, "R3 busy during sequence", go_busy, 1);
            wait_pc(base + n + 2);
            check(sample_on == 1'b0, "R4 switch open in bit decisions", sample_on, 0);
            check(dac_code == 10'h200, "R2 first trial code", dac_code, 10'h200);
        end
    endtask

    task automatic run_conv(input logic [2:0] code, input logic [RES_W-1:0] v, input bit probe);
        int unsigned base;
        start_conv(code, v, 1, probe, base);
        while (sb.size() != 0) @(negedge clk);
        free_tick = base + acq_n(code) + 12 + 2;
        last_res  = v;
    endtask

    initial begin
        int unsigned base, a;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check(result == '0, "R1 result", result, 0);
        check(irq_flag == 1'b0, "R1 flag", irq_flag, 0);
        check(go_busy == 1'b0, "R1 busy", go_busy, 0);
        check(sample_on == 1'b1, "R1 switch", sample_on, 1);
        check(dac_code == '0, "R1 dac", dac_code, 0);

        run_conv(3'd0, 10'h2AA, 1);
        run_conv(3'd1, 10'h155, 0);
        run_conv(3'd2, 10'h3FF, 1);
        run_conv(3'd3, 10'h000, 0);
        run_conv(3'd4, 10'h200, 0);
        run_conv(3'd5, 10'h1FF, 1);
        run_conv(3'd6, 10'h001, 0);
        run_conv(3'd7, 10'h3FE, 1);

        // R8 flag stays set without a clear
        wait_pc(pc + 10);
        check(irq_flag == 1'b1, "R8 flag sticky", irq_flag, 1);
        @(negedge clk); #1 irq_clr = 1'b1;
        @(negedge clk); #1 irq_clr = 1'b0;
        check(irq_flag == 1'b0, "R8 flag cleared", irq_flag, 0);

        // R9 software write of the result
        @(negedge clk); #1 res_wr = 1'b1; res_wdata = 10'h0C3;
        @(negedge clk); #1 res_wr = 1'b0;
        check(result == 10'h0C3, "R9 software write", result, 10'h0C3);
        last_res = 10'h0C3;

        // R6 abort mid-conversion
        start_conv(3'd2, 10'h111, 0, 0, base);
        wait_pc(base + 4 + 5);
        @(negedge clk); #1 go_clr = 1'b1;
        a = adj_pc() + 1;
        @(negedge clk); #1 go_clr = 1'b0;
        check(go_busy == 1'b0, "R6 busy cleared by abort", go_busy, 0);
        wait_pc(a);
        check(result == last_res, "R6 result kept", result, last_res);
        check(irq_flag == 1'b0, "R6 no flag", irq_flag, 0);
        check(sample_on == 1'b1, "R6 switch closed after abort", sample_on, 1);
        free_tick = a + 2;

        // R7 start during discharge is held
        run_conv(3'd0, 10'h0F0, 0);
        // R7 back-to-back start lands in discharge wait
        run_conv(3'd1, 10'h333, 0);
        run_conv(3'd0, 10'h07C, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule